// File: doc/BRIEF.md
# Segmented Physical Address Unit

This block turns a 16-bit offset into a physical memory address by adding it to a segment base. It holds four 16-bit segment registers: extra, code, stack and data. A segment's base is its register value shifted left by four bits, so bases fall on 16-byte boundaries. Many different segment:offset pairs can reach the same byte. A write port loads one segment register, chosen by a 2-bit index. The same index encoding picks the segment when a data access overrides its default.

Each request carries an offset, an access kind and an optional segment override. The kind selects the segment. Code fetches always use the code segment and stack accesses always use the stack segment. Data accesses use the data segment unless an override names another one. I/O accesses bypass segmentation: the offset is passed through unchanged.

The adder is one bit wider than the 20-bit physical space. When the wrap-compatibility input is high, bit 20 is forced to zero, so an address past the top of memory wraps to the bottom. When it is low, the carry is kept in bit 20. The result is registered with one cycle of latency. The result also carries two flags: one for the interrupt vector area at the bottom of memory, and one for the 16-byte reset area at the top of the 20-bit space.

Top module: `seg_addr_unit`

## Requirements
- R1: A memory request produces (segment << 4) + zero-extended offset as a 21-bit sum; with wrapCompat low the carry into bit 20 is kept.
- R2: With wrapCompat high, bit 20 of the address is zero, so segment FF00h with offset 8000h yields 07000h.
- R3: Segment index encoding is extra=00, code=01, stack=10, data=11, for both the write port and the override field. A write takes effect for requests from the next cycle on. A request in the same cycle as a write to its segment uses the old value.
- R4: Access kind encoding is code=00, stack=01, data=10, I/O=11. Code fetches use segment 01 and stack accesses use segment 10, whatever the override inputs say.
- R5: Data accesses use segment 11 when the override enable is low, and the segment given by the override index when it is high.
- R6: An I/O request outputs the offset zero-extended in bits 15:0, bits 20:16 zero, segment index 00, and both region flags low.
- R7: addrValid goes high in the cycle after a request and is low otherwise. Address, index and flags hold their last values while no request arrives.
- R8: After reset all segment registers read zero and all outputs are zero.
- R9: inVecRegion is high for a memory request whose address lies in 00000h to 0007Fh.
- R10: inResetRegion is high for a memory request whose address lies in 0FFFF0h to 0FFFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | Segment register write strobe |
| segWrIdx | input | 2 | Index of segment register to write |
| segWrData | input | 16 | Value to write |
| reqValid | input | 1 | Address request strobe |
| reqOffset | input | 16 | Request offset |
| reqKind | input | 2 | Access kind: code, stack, data, I/O |
| reqOvrEn | input | 1 | Segment override enable (data only) |
| reqOvrIdx | input | 2 | Override segment index |
| wrapCompat | input | 1 | Force address bit 20 to zero |
| addrValid | output | 1 | Address output valid |
| addrOut | output | 21 | Physical address |
| segIdxOut | output | 2 | Segment index used |
| inVecRegion | output | 1 | Address in interrupt vector area |
| inResetRegion | output | 1 | Address in reset area |

## Verification
A corrupt segment register shows up as a wrong addrOut on the very next request that selects that segment. The error is off by a multiple of 16 and is seen one cycle after the request. A wrong selection appears on segIdxOut in that same cycle, and it also moves the address, so code, stack, data, override and I/O requests are all driven against distinct segment values. A lost or kept bit-20 carry, or a stale region flag, shows up on the first request that straddles the top of memory or a region boundary. The vector table exercises those boundaries on both sides.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [1:0] {
    SEG_EXTRA = 2'b00,
    SEG_CODE  = 2'b01,
    SEG_STACK = 2'b10,
    SEG_DATA  = 2'b11
  } segIdx_e;

  typedef enum logic [1:0] {
    ACC_CODE  = 2'b00,
    ACC_STACK = 2'b01,
    ACC_DATA  = 2'b10,
    ACC_IO    = 2'b11
  } accKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       capture;
    logic [1:0] segSel;
    logic       bypass;
    logic       clip20;
  } segCtrl_t;

endpackage

// File: rtl/seg_ctrl.sv
module seg_ctrl
  import seg_pkg::*;
(
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic       reqOvrEn,
  input  logic [1:0] reqOvrIdx,
  input  logic       wrapCompat,
  output segCtrl_t   strb
);

  always_comb begin
    strb.capture = reqValid;
    strb.clip20  = wrapCompat;
    strb.bypass  = 1'b0;
    strb.segSel  = SEG_DATA;
    unique case (accKind_e'(reqKind))
      ACC_CODE:  strb.segSel = SEG_CODE;
      ACC_STACK: strb.segSel = SEG_STACK;
      ACC_DATA:  strb.segSel = reqOvrEn ? reqOvrIdx : SEG_DATA;
      ACC_IO: begin
        strb.segSel = SEG_EXTRA;
        strb.bypass = 1'b1;
      end
      default:   strb.segSel = SEG_DATA;
    endcase
  end

endmodule

// File: rtl/seg_datapath.sv
module seg_datapath
  import seg_pkg::*;
#(
  parameter int SEG_W   = 16,
  parameter int OFFS_W  = 16,
  parameter int SHIFT   = 4,
  parameter int NUM_SEG = 4,
  parameter int VEC_TOP = 'h7F
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              segWrEn,
  input  logic [$clog2(NUM_SEG)-1:0]        segWrIdx,
  input  logic [SEG_W-1:0]                  segWrData,
  input  logic [OFFS_W-1:0]                 reqOffset,
  input  segCtrl_t                          strb,
  output logic                              addrValid,
  output logic [SEG_W+SHIFT:0]              addrOut,
  output logic [$clog2(NUM_SEG)-1:0]        segIdxOut,
  output logic                              inVecRegion,
  output logic                              inResetRegion
);

  localparam int IDX_W   = $clog2(NUM_SEG);
  localparam int PHYS_W  = SEG_W + SHIFT;
  localparam int ADDR_W  = PHYS_W + 1;
  localparam logic [ADDR_W-1:0] RST_LAST  = ADDR_W'((64'd1 << PHYS_W) - 1);
  localparam logic [ADDR_W-1:0] RST_FIRST = RST_LAST - ADDR_W'((64'd1 << SHIFT) - 1);
  localparam logic [ADDR_W-1:0] VEC_LAST  = ADDR_W'(VEC_TOP);

  logic [SEG_W-1:0]  segRegs [NUM_SEG];
  logic [SEG_W-1:0]  selSeg;
  logic [ADDR_W-1:0] segBase;
  logic [ADDR_W-1:0] offExt;
  logic [ADDR_W-1:0] rawSum;
  logic [ADDR_W-1:0] nextAddr;
  logic              nextVec;
  logic              nextRst;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        segRegs[i] <= '0;
      end else if (segWrEn && segWrIdx == IDX_W'(i)) begin
        segRegs[i] <= segWrData;
      end
    end
  end

  assign selSeg  = segRegs[strb.segSel[IDX_W-1:0]];
  assign segBase = {1'b0, selSeg, {SHIFT{1'b0}}};
  assign offExt  = {{(ADDR_W-OFFS_W){1'b0}}, reqOffset};
  assign rawSum  = segBase + offExt;

  always_comb begin
    nextAddr = strb.bypass ? offExt : rawSum;
    if (strb.clip20) begin
      nextAddr[ADDR_W-1] = 1'b0;
    end
    nextVec = !strb.bypass && (nextAddr <= VEC_LAST);
    nextRst = !strb.bypass && (nextAddr >= RST_FIRST) && (nextAddr <= RST_LAST);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrValid     <= 1'b0;
      addrOut       <= '0;
      segIdxOut     <= '0;
      inVecRegion   <= 1'b0;
      inResetRegion <= 1'b0;
    end else begin
      addrValid <= strb.capture;
      if (strb.capture) begin
        addrOut       <= nextAddr;
        segIdxOut     <= strb.segSel[IDX_W-1:0];
        inVecRegion   <= nextVec;
        inResetRegion <= nextRst;
      end
    end
  end

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_pkg::*;
#(
  parameter int SEG_W  = 16,
  parameter int OFFS_W = 16,
  parameter int SHIFT  = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   segWrEn,
  input  logic [1:0]             segWrIdx,
  input  logic [SEG_W-1:0]       segWrData,
  input  logic                   reqValid,
  input  logic [OFFS_W-1:0]      reqOffset,
  input  logic [1:0]             reqKind,
  input  logic                   reqOvrEn,
  input  logic [1:0]             reqOvrIdx,
  input  logic                   wrapCompat,
  output logic                   addrValid,
  output logic [SEG_W+SHIFT:0]   addrOut,
  output logic [1:0]             segIdxOut,
  output logic                   inVecRegion,
  output logic                   inResetRegion
);

  segCtrl_t strb;

  seg_ctrl u_ctrl (
    .reqValid   (reqValid),
    .reqKind    (reqKind),
    .reqOvrEn   (reqOvrEn),
    .reqOvrIdx  (reqOvrIdx),
    .wrapCompat (wrapCompat),
    .strb       (strb)
  );

  seg_datapath #(
    .SEG_W   (SEG_W),
    .OFFS_W  (OFFS_W),
    .SHIFT   (SHIFT),
    .NUM_SEG (4),
    .VEC_TOP ('h7F)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .segWrEn       (segWrEn),
    .segWrIdx      (segWrIdx),
    .segWrData     (segWrData),
    .reqOffset     (reqOffset),
    .strb          (strb),
    .addrValid     (addrValid),
    .addrOut       (addrOut),
    .segIdxOut     (segIdxOut),
    .inVecRegion   (inVecRegion),
    .inResetRegion (inResetRegion)
  );

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [15:0] reqOffset,
  input logic [1:0]  reqKind,
  input logic        reqOvrEn,
  input logic [1:0]  reqOvrIdx,
  input logic        wrapCompat,
  input logic        addrValid,
  input logic [20:0] addrOut,
  input logic [1:0]  segIdxOut,
  input logic        inVecRegion,
  input logic        inResetRegion
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid); // R7

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(addrOut) && $stable(segIdxOut)); // R7

  AST_BIT20_CLIPPED: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && wrapCompat |=> !addrOut[20]); // R2

  AST_CODE_SEG: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqKind == 2'b00 |=> segIdxOut == 2'b01); // R4

  AST_STACK_SEG: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqKind == 2'b01 |=> segIdxOut == 2'b10); // R4

  AST_DATA_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqKind == 2'b10 && !reqOvrEn |=> segIdxOut == 2'b11); // R5

  AST_DATA_OVERRIDE: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqKind == 2'b10 && reqOvrEn |=> segIdxOut == $past(reqOvrIdx)); // R5

  AST_IO_PASSTHRU: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqKind == 2'b11 |=>
      addrOut == {5'b0, $past(reqOffset)} && !inVecRegion && !inResetRegion); // R6

  AST_REGIONS_DISJOINT: assert property (@(posedge clk) disable iff (!rstN)
    !(inVecRegion && inResetRegion)); // R9

  AST_RESET_FLAG_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    inResetRegion |-> addrOut[20:4] == 17'h0FFFF); // R10

endmodule

bind seg_addr_unit seg_addr_chk u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .reqValid      (reqValid),
  .reqOffset     (reqOffset),
  .reqKind       (reqKind),
  .reqOvrEn      (reqOvrEn),
  .reqOvrIdx     (reqOvrIdx),
  .wrapCompat    (wrapCompat),
  .addrValid     (addrValid),
  .addrOut       (addrOut),
  .segIdxOut     (segIdxOut),
  .inVecRegion   (inVecRegion),
  .inResetRegion (inResetRegion)
);

// File: tb/tb_seg_addr_unit.sv
module tb_seg_addr_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        segWrEn;
  logic [1:0]  segWrIdx;
  logic [15:0] segWrData;
  logic        reqValid;
  logic [15:0] reqOffset;
  logic [1:0]  reqKind;
  logic        reqOvrEn;
  logic [1:0]  reqOvrIdx;
  logic        wrapCompat;
  logic        addrValid;
  logic [20:0] addrOut;
  logic [1:0]  segIdxOut;
  logic        inVecRegion;
  logic        inResetRegion;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  seg_addr_unit dut (
    .clk(clk), .rstN(rstN),
    .segWrEn(segWrEn), .segWrIdx(segWrIdx), .segWrData(segWrData),
    .reqValid(reqValid), .reqOffset(reqOffset), .reqKind(reqKind),
    .reqOvrEn(reqOvrEn), .reqOvrIdx(reqOvrIdx), .wrapCompat(wrapCompat),
    .addrValid(addrValid), .addrOut(addrOut), .segIdxOut(segIdxOut),
    .inVecRegion(inVecRegion), .inResetRegion(inResetRegion)
  );

  // {kind, ovrEn, ovrIdx, offset, wrap, expAddr, expIdx, expVec, expRst}
  // segments loaded first: extra=1234h code=FFFFh stack=FF00h data=0000h
  localparam int NV = 15;
  localparam logic [46:0] VEC [NV] = '{
    {2'd0, 1'b0, 2'd0, 16'h0000, 1'b0, 21'h0FFFF0, 2'd1, 1'b0, 1'b1}, // R4 R10 low edge
    {2'd0, 1'b0, 2'd0, 16'h000F, 1'b0, 21'h0FFFFF, 2'd1, 1'b0, 1'b1}, // R10 top
    {2'd0, 1'b0, 2'd0, 16'h0010, 1'b0, 21'h100000, 2'd1, 1'b0, 1'b0}, // R1 carry kept
    {2'd0, 1'b0, 2'd0, 16'h0010, 1'b1, 21'h000000, 2'd1, 1'b1, 1'b0}, // R2 wrap to zero
    {2'd1, 1'b0, 2'd0, 16'h8000, 1'b1, 21'h007000, 2'd2, 1'b0, 1'b0}, // R2 FF00:8000
    {2'd1, 1'b0, 2'd0, 16'h8000, 1'b0, 21'h107000, 2'd2, 1'b0, 1'b0}, // R1
    {2'd1, 1'b1, 2'd0, 16'h0001, 1'b0, 21'h0FF001, 2'd2, 1'b0, 1'b0}, // R4 override ignored
    {2'd2, 1'b0, 2'd0, 16'h007F, 1'b0, 21'h00007F, 2'd3, 1'b1, 1'b0}, // R5 R9 edge
    {2'd2, 1'b0, 2'd0, 16'h0080, 1'b0, 21'h000080, 2'd3, 1'b0, 1'b0}, // R9 just past
    {2'd2, 1'b1, 2'd0, 16'h0005, 1'b0, 21'h012345, 2'd0, 1'b0, 1'b0}, // R5 extra
    {2'd2, 1'b1, 2'd1, 16'h0005, 1'b0, 21'h0FFFF5, 2'd1, 1'b0, 1'b1}, // R5 code
    {2'd2, 1'b1, 2'd2, 16'hFFFF, 1'b0, 21'h10EFFF, 2'd2, 1'b0, 1'b0}, // R5 stack
    {2'd3, 1'b0, 2'd0, 16'hBEEF, 1'b0, 21'h00BEEF, 2'd0, 1'b0, 1'b0}, // R6
    {2'd3, 1'b1, 2'd2, 16'h0010, 1'b0, 21'h000010, 2'd0, 1'b0, 1'b0}, // R6 no vec flag
    {2'd0, 1'b1, 2'd3, 16'h0000, 1'b1, 21'h0FFFF0, 2'd1, 1'b0, 1'b1}  // R4 override ignored
  };

  task automatic check(input string req, input logic [20:0] expA, input logic [1:0] expI,
                       input logic expV, input logic expR, input logic expValid);
    nTests++;
    if (addrOut !== expA || segIdxOut !== expI || inVecRegion !== expV ||
        inResetRegion !== expR || addrValid !== expValid) begin
      nFail++;
      $display("FAIL %s: got addr=%h idx=%0d vec=%b rst=%b v=%b, exp addr=%h idx=%0d vec=%b rst=%b v=%b",
               req, addrOut, segIdxOut, inVecRegion, inResetRegion, addrValid,
               expA, expI, expV, expR, expValid);
    end
  endtask

  task automatic writeSeg(input logic [1:0] idx, input logic [15:0] val);
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = idx; segWrData = val; reqValid = 1'b0;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  task automatic request(input logic [1:0] kind, input logic ovrEn, input logic [1:0] ovrIdx,
                         input logic [15:0] offs, input logic wrap);
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqOvrEn = ovrEn; reqOvrIdx = ovrIdx;
    reqOffset = offs; wrapCompat = wrap;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; segWrEn = 1'b0; segWrIdx = '0; segWrData = '0;
    reqValid = 1'b0; reqOffset = '0; reqKind = '0; reqOvrEn = 1'b0;
    reqOvrIdx = '0; wrapCompat = 1'b0;
    repeat (3) @(negedge clk);
    check("R8 reset outputs", 21'h0, 2'd0, 1'b0, 1'b0, 1'b0);
    rstN = 1'b1;

    // R8: segments zero after reset, visible via extra segment
    request(2'd2, 1'b1, 2'd0, 16'h1234, 1'b0);
    check("R8 extra seg zero", 21'h01234, 2'd0, 1'b0, 1'b0, 1'b1);
    request(2'd0, 1'b0, 2'd0, 16'h0040, 1'b0);
    check("R8 code seg zero", 21'h00040, 2'd1, 1'b1, 1'b0, 1'b1);

    writeSeg(2'd0, 16'h1234);
    writeSeg(2'd1, 16'hFFFF);
    writeSeg(2'd2, 16'hFF00);
    writeSeg(2'd3, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      request(v[46:45], v[44], v[43:42], v[41:26], v[25]);
      check($sformatf("R1/R2/R4/R5/R6/R9/R10 vector %0d", i),
            v[24:4], v[3:2], v[1], v[0], 1'b1);
    end

    // R7: idle cycle drops valid and holds data (last vector result)
    @(negedge clk);
    check("R7 hold while idle", 21'h0FFFF0, 2'd1, 1'b0, 1'b1, 1'b0);

    // R3: same-cycle write to data seg, request sees old value (0)
    @(negedge clk);
    segWrEn = 1'b1; segWrIdx = 2'd3; segWrData = 16'h1000;
    reqValid = 1'b1; reqKind = 2'd2; reqOvrEn = 1'b0; reqOffset = 16'h0100; wrapCompat = 1'b0;
    @(negedge clk);
    segWrEn = 1'b0; reqValid = 1'b0;
    check("R3 same-cycle old value", 21'h00100, 2'd3, 1'b0, 1'b0, 1'b1);
    request(2'd2, 1'b0, 2'd0, 16'h0100, 1'b0);
    check("R3 new value next cycle", 21'h10100, 2'd3, 1'b0, 1'b0, 1'b1);

    // R3: write by index 00 lands in extra only
    writeSeg(2'd0, 16'h0ABC);
    request(2'd2, 1'b1, 2'd0, 16'h0003, 1'b0);
    check("R3 extra write", 21'h0ABC3, 2'd0, 1'b0, 1'b0, 1'b1);
    request(2'd1, 1'b0, 2'd0, 16'h0003, 1'b0);
    check("R3 stack untouched", 21'h0FF003, 2'd2, 1'b0, 1'b0, 1'b1);

    // R1 R2: same address with and without gate
    request(2'd2, 1'b1, 2'd1, 16'hFFFF, 1'b0);
    check("R1 max sum", 21'h10FFEF, 2'd1, 1'b0, 1'b0, 1'b1);
    request(2'd2, 1'b1, 2'd1, 16'hFFFF, 1'b1);
    check("R2 max sum clipped", 21'h00FFEF, 2'd1, 1'b0, 1'b0, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule